// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block holds a microprogram in a RAM control store and, once started, issues one microinstruction per clock by stepping a microprogram counter through that store. Each stored word has a control field for the datapath and a sequencing part. The sequencing part selects how the next address is formed: step forward by one, take a literal target, dispatch on opcode bits from the instruction register, or branch on a selected status flag. The datapath decoding of the control field is done elsewhere.

After reset the block is halted and waits to be loaded. Words come in over a valid/ready load port. `ld_ready` is high exactly while the machine is halted. A word is written when `ld_valid` and `ld_ready` are both high at a clock edge. No back-pressure is applied while halted. While running, `ld_ready` is low. An offered word is then dropped rather than held, and it raises a one-cycle error pulse. A `ld_done` strobe starts execution at address 0. A `halt` request stops the machine so the store can be patched and the program run again.

A word is `{ctrl[CTRL_W-1:0], seq_op[1:0], fsel[1:0], jump[7:0]}`, with `jump` in the low bits. With the default parameters the word is 28 bits wide.

Top module: `useq_top`

## Requirements
- R1: After reset, `running` is 0, `uaddr` is 0, `ld_ready` is 1 and `wr_err` is 0.
- R2: When `ld_valid` and `ld_ready` are both high at a clock edge, `ld_data` is written to the store word at `ld_addr`. `uword` always shows the stored word at `uaddr`, with no cycle of delay.
- R3: While halted, a `ld_done` strobe makes `running` rise at the next edge, and the first address issued is 0.
- R4: When `seq_op`=0 (step), the next `uaddr` is the current `uaddr` plus one, modulo 256.
- R5: When `seq_op`=1 (jump), the next `uaddr` is the word's `jump` field.
- R6: When `seq_op`=2 (dispatch), the next `uaddr` is {2'b01, `ir_opcode`[5:0]}.
- R7: When `seq_op`=3 (branch), the next `uaddr` is `jump` if `status_flags[fsel]` is 1, and the current `uaddr` plus one otherwise.
- R8: While running, exactly one new address is issued on every clock cycle.
- R9: A `halt` while running clears `running` and sets `uaddr` to 0 at the next edge and raises `ld_ready`. Words written afterwards replace the old ones in the next run.
- R10: A load offered while running is not written, and `ld_ready` is low. `wr_err` is high for exactly the one cycle after that offer.
- R11: While halted, `uaddr` stays 0 whatever the store holds.
- R12: A store write and `ld_done` in the same cycle are both honoured. The first word issued comes from the updated store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Store accepts a load (machine halted) |
| ld_addr | input | 8 | Store address of the offered word |
| ld_data | input | 28 | Offered word |
| ld_done | input | 1 | Start strobe: run from address 0 |
| halt | input | 1 | Stop execution and return to loading |
| ir_opcode | input | 6 | Opcode bits used by dispatch |
| status_flags | input | 4 | Status signals tested by branch |
| uaddr | output | 8 | Current microprogram address |
| uword | output | 28 | Microinstruction at `uaddr` |
| running | output | 1 | Execution active |
| wr_err | output | 1 | Pulse: a load was offered while running |

## Verification
Two pairs of events can meet in one cycle. The first is a store write and the start strobe. The bench patches address 0 with a jump in the same cycle that it raises `ld_done`, and the scoreboard requires the first issued word to be the patched one, followed by its jump target. The second is a load offer against a running sequencer. The bench offers a junk word to an address the program reaches again later, and expects `ld_ready` low, one `wr_err` pulse, and the original word when that address is next issued.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int SEQ_W = 2;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_STEP     = 2'd0,
    SEQ_JUMP     = 2'd1,
    SEQ_DISPATCH = 2'd2,
    SEQ_BRANCH   = 2'd3
  } seq_op_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 28
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_word;
  end

  // combinational read: the word for the current address is visible at once
  assign rd_word = cells[rd_addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OPC_W     = 6,
  parameter int FLAG_N    = 4,
  parameter int DISP_PAGE = 1,
  parameter int FSEL_W    = 2
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  seq_op_e           op,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [ADDR_W-1:0] target,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_N-1:0] flags,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam logic [ADDR_W-1:0] DISP_BASE = ADDR_W'(DISP_PAGE) << OPC_W;
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

  logic              cond_hit;
  logic [ADDR_W-1:0] inc_addr;
  logic [ADDR_W-1:0] disp_addr;

  generate
    if (FLAG_N == 1) begin : g_one_flag
      logic unused_fsel;
      assign unused_fsel = ^fsel;
      assign cond_hit = flags[0];
    end else begin : g_flag_mux
      assign cond_hit = flags[fsel];
    end
  endgenerate

  assign inc_addr  = cur_addr + ONE;
  assign disp_addr = DISP_BASE | ADDR_W'(opcode);

  always_comb begin
    unique case (op)
      SEQ_STEP:     nxt_addr = inc_addr;
      SEQ_JUMP:     nxt_addr = target;
      SEQ_DISPATCH: nxt_addr = disp_addr;
      SEQ_BRANCH:   nxt_addr = cond_hit ? target : inc_addr;
      default:      nxt_addr = inc_addr;
    endcase
  end
endmodule

// File: rtl/useq_ctl.sv
module useq_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_done,
  input  logic              halt,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic              running,
  output logic [ADDR_W-1:0] upc,
  output logic              ld_ready,
  output logic              wr_en,
  output logic              wr_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      upc     <= '0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= running & ld_valid;
      if (halt) begin
        running <= 1'b0;
        upc     <= '0;
      end else if (!running) begin
        upc <= '0;
        if (ld_done) running <= 1'b1;
      end else begin
        upc <= nxt_addr;
      end
    end
  end

  assign ld_ready = ~running;
  assign wr_en    = ld_valid & ~running;
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_W    = 16,
  parameter int OPC_W     = 6,
  parameter int FLAG_N    = 4,
  parameter int DISP_PAGE = 1,
  localparam int FSEL_W   = (FLAG_N > 1) ? $clog2(FLAG_N) : 1,
  localparam int WORD_W   = CTRL_W + SEQ_W + FSEL_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_done,
  input  logic              halt,
  input  logic [OPC_W-1:0]  ir_opcode,
  input  logic [FLAG_N-1:0] status_flags,
  output logic [ADDR_W-1:0] uaddr,
  output logic [WORD_W-1:0] uword,
  output logic              running,
  output logic              wr_err
);
  localparam int FSEL_LO = ADDR_W;
  localparam int OP_LO   = ADDR_W + FSEL_W;

  logic              wr_en;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] f_target;
  logic [FSEL_W-1:0] f_fsel;
  seq_op_e           f_op;

  assign f_target = uword[ADDR_W-1:0];
  assign f_fsel   = uword[FSEL_LO +: FSEL_W];
  assign f_op     = seq_op_e'(uword[OP_LO +: SEQ_W]);

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (ld_addr),
    .wr_word (ld_data),
    .rd_addr (uaddr),
    .rd_word (uword)
  );

  useq_next #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .FLAG_N(FLAG_N),
    .DISP_PAGE(DISP_PAGE), .FSEL_W(FSEL_W)
  ) u_next (
    .cur_addr (uaddr),
    .op       (f_op),
    .fsel     (f_fsel),
    .target   (f_target),
    .opcode   (ir_opcode),
    .flags    (status_flags),
    .nxt_addr (nxt_addr)
  );

  useq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_done  (ld_done),
    .halt     (halt),
    .nxt_addr (nxt_addr),
    .running  (running),
    .upc      (uaddr),
    .ld_ready (ld_ready),
    .wr_en    (wr_en),
    .wr_err   (wr_err)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 28,
  parameter int FSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              halt,
  input logic [ADDR_W-1:0] uaddr,
  input logic [WORD_W-1:0] uword,
  input logic              running,
  input logic              wr_err
);
  localparam int OP_LO = ADDR_W + FSEL_W;

  logic [1:0] op_bits;
  assign op_bits = uword[OP_LO +: 2];

  // R3
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (uaddr == '0));

  // R4
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !halt && op_bits == 2'd0) |=> (uaddr == ADDR_W'($past(uaddr) + 1)));

  // R5
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !halt && op_bits == 2'd1) |=> (uaddr == $past(uword[ADDR_W-1:0])));

  // R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && halt) |=> (!running && uaddr == '0 && ld_ready));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !ld_ready);

  // R10
  busy_offer_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ld_valid) |=> wr_err);

  // R10
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ld_valid) |=> !wr_err);

  // R11
  idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (uaddr == '0));
endmodule

bind useq_top useq_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .FSEL_W(FSEL_W)
) u_useq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_valid (ld_valid),
  .ld_ready (ld_ready),
  .halt     (halt),
  .uaddr    (uaddr),
  .uword    (uword),
  .running  (running),
  .wr_err   (wr_err)
);

// File: tb/test_useq_top.sv
module test_useq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [WW-1:0] ld_data = '0;
  logic          ld_done = 1'b0;
  logic          halt = 1'b0;
  logic [5:0]    ir_opcode = 6'h05;
  logic [3:0]    status_flags = 4'b0100;
  logic [AW-1:0] uaddr;
  logic [WW-1:0] uword;
  logic          running;
  logic          wr_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [WW-1:0] model [256];
  int            exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_done(ld_done), .halt(halt),
    .ir_opcode(ir_opcode), .status_flags(status_flags), .uaddr(uaddr),
    .uword(uword), .running(running), .wr_err(wr_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(logic [15:0] c, logic [1:0] op,
                                       logic [1:0] fs, logic [7:0] j);
    return {c, op, fs, j};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load(int a, logic [WW-1:0] w);
    ld_valid = 1'b1; ld_addr = AW'(a); ld_data = w;
    model[a] = w;
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic expect_at(int a, string tag);
    exp_q.push_back(a);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic stop_run();
    halt = 1'b1;
    tick();
    halt = 1'b0;
    @(negedge clk);
    check("R9 running", running, 0);
    check("R9 uaddr", uaddr, 0);
    check("R9 ld_ready", ld_ready, 1);
  endtask

  // scoreboard monitor: one expected address per running cycle (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (running && exp_q.size() != 0) begin
        automatic int    a = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check({t, " addr"}, uaddr, a);
        check({t, " R2 word"}, uword, model[a]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 running", running, 0);
    check("R1 uaddr", uaddr, 0);
    check("R1 ld_ready", ld_ready, 1);
    check("R1 wr_err", wr_err, 0);

    tick();
    load(0,   mk(16'hA000, 2'd0, 2'd0, 8'd0));
    load(1,   mk(16'hA001, 2'd1, 2'd0, 8'd10));
    load(10,  mk(16'hA00A, 2'd3, 2'd2, 8'd20));
    load(20,  mk(16'hA014, 2'd3, 2'd1, 8'd30));
    load(21,  mk(16'hA015, 2'd2, 2'd0, 8'd0));
    load(69,  mk(16'hA045, 2'd1, 2'd0, 8'd255));
    load(255, mk(16'hA0FF, 2'd0, 2'd0, 8'd0));
    @(negedge clk);
    // R11: store holds words but the address stays parked
    check("R11 uaddr", uaddr, 0);
    check("R11 running", running, 0);

    // run 1: every sequencing kind, wrap at 255, revisit of 69
    for (int k = 0; k < 2; k++) begin
      expect_at(0,   "R3");
      expect_at(1,   "R4");
      expect_at(10,  "R5");
      expect_at(20,  "R7 taken");
      expect_at(21,  "R7 not-taken");
      expect_at(69,  "R6");
      expect_at(255, "R5");
    end
    expect_at(0, "R4 wrap");
    tick();
    ld_done = 1'b1;
    tick();
    ld_done = 1'b0;
    tick(); tick();
    // R10: offer a junk word to address 69 while running
    ld_valid = 1'b1; ld_addr = 8'd69; ld_data = mk(16'hDEAD, 2'd0, 2'd0, 8'd0);
    @(negedge clk);
    check("R10 ld_ready", ld_ready, 0);
    check("R10 wr_err before", wr_err, 0);
    tick();
    ld_valid = 1'b0;
    @(negedge clk);
    check("R10 wr_err pulse", wr_err, 1);
    @(negedge clk);
    check("R10 wr_err single", wr_err, 0);
    drain();
    stop_run();

    // run 2: patch address 20 to a taken branch into a new word
    load(20, mk(16'hB014, 2'd3, 2'd2, 8'd30));
    load(30, mk(16'hB01E, 2'd1, 2'd0, 8'd0));
    expect_at(0,  "R9 rerun");
    expect_at(1,  "R4");
    expect_at(10, "R5");
    expect_at(20, "R7 taken");
    expect_at(30, "R9 patched");
    expect_at(0,  "R5");
    ld_done = 1'b1;
    tick();
    ld_done = 1'b0;
    drain();
    stop_run();

    // run 3: write to address 0 in the same cycle as the start strobe
    load(50, mk(16'hC032, 2'd0, 2'd0, 8'd0));
    load(51, mk(16'hC033, 2'd1, 2'd0, 8'd0));
    expect_at(0,  "R12 first");
    expect_at(50, "R12 target");
    expect_at(51, "R4");
    expect_at(0,  "R5");
    expect_at(50, "R12 again");
    ld_valid = 1'b1; ld_addr = 8'd0; ld_data = mk(16'hC000, 2'd1, 2'd0, 8'd50);
    model[0] = ld_data;
    ld_done = 1'b1;
    tick();
    ld_valid = 1'b0;
    ld_done = 1'b0;
    drain();
    stop_run();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule